// File: doc/BRIEF.md
# Bus Width Downsizing Adapter

This block connects a 32-bit memory-mapped master to an external slave whose data path is 16 or 8 bits wide. Each master read or write becomes a short series of narrow slave transfers. The adapter drives the slave chip-select, read strobe and write strobe itself. On a read it collects the narrow results into one 32-bit word and hands that word back to the master.

The master always issues full-width accesses. Its byte enables are the only sign of which lanes software actually wants. The adapter has a mode input, `skip_en`. When `skip_en` is high, a narrow beat whose byte-enable slice is all zero is never placed on the slave bus. A 16-bit or 8-bit software access to a FIFO or to a clear-on-read register therefore produces exactly one slave strobe instead of two or four. When `skip_en` is low, every beat is issued, as in a plain width split.

The slave side is handled by one small state machine. A beat holds its strobes for `STROBE_CYC` cycles and is followed by one idle gap cycle. The next wanted beat is found in a single cycle, however many beats in between are skipped.

Top module: `bus_downsizer`

## Requirements
- R1: Reset state. After reset, `s_cs`, `s_rd` and `s_wr` are low, `m_rvalid` is low and `m_waitreq` is high.
- R2: Beat order and lanes. An access is split into BEATS = 32/SLV_DW beats in ascending order.
  - Beat b goes to slave address {m_addr, b}.
  - Beat b carries data bits [b*SLV_DW +: SLV_DW] and byte-enable bits [b*SLV_DW/8 +: SLV_DW/8].
  - So the lowest lane goes first, at the base address.
- R3: Read gathering. A read returns one 32-bit word in which lane b holds the slave data of beat b. `m_rvalid` is high for exactly one cycle, the single cycle in which `m_waitreq` is low.
- R4: Skip mode. With skip mode in force, a beat whose byte-enable slice is zero gets no chip-select and no strobe. On a read, the lanes of such a beat return zero.
- R5: Split mode. With skip mode off, every beat is issued, whatever its byte enables.
- R6: Empty access. With skip mode in force, an access with `m_be` = 0 makes no slave transfer. It completes with `m_waitreq` low at the first falling edge after the acceptance edge, and a read returns zero.
- R7: Strobe timing. During a beat, `s_cs` and its strobe stay high for exactly STROBE_CYC cycles with a stable `s_addr`. The strobes are low for at least one cycle between beats, and `s_rd`/`s_wr` are never high without `s_cs`.
- R8: Writes. On a write, each issued beat presents its data slice and byte-enable slice with `s_wr`. `s_rd` is never high during a write, and the slave byte lanes whose enables are low stay unchanged.
- R9: Latency. With n issued beats, `m_waitreq` goes low 1 + n*(STROBE_CYC+1) cycles after the edge that accepts the request.
- R10: Mode sampling. `skip_en` is sampled on the edge that accepts a request. Changing it while the access is in progress has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| skip_en | input | 1 | 1 = drop beats with no enabled byte lanes |
| m_addr | input | MADDR_W | Master word address (32-bit words) |
| m_read | input | 1 | Master read request, held while `m_waitreq` is high |
| m_write | input | 1 | Master write request, held while `m_waitreq` is high |
| m_be | input | 4 | Master byte enables, bit i selects byte lane i |
| m_wdata | input | 32 | Master write data |
| m_waitreq | output | 1 | High until the current access completes |
| m_rdata | output | 32 | Assembled read word |
| m_rvalid | output | 1 | One-cycle read-data-valid |
| s_cs | output | 1 | Slave chip-select, active high |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_addr | output | MADDR_W+log2(BEATS) | Slave address of the current beat |
| s_be | output | SLV_DW/8 | Slave byte enables of the current beat |
| s_wdata | output | SLV_DW | Slave write data of the current beat |
| s_rdata | input | SLV_DW | Slave read data, sampled on the last strobe cycle |

## Verification
Two things can land on the same edge.

- **Mode input and acceptance.** A change of `skip_en` can coincide with the edge that accepts a request. The bench starts a half-lane read with skip mode on, then flips `skip_en` on the next falling edge, while the first beat is already under way. It judges the result by the number of slave strobes and the final word: both must follow the mode seen at acceptance.
- **Completion and a new request.** The completion cycle can meet a new request that the master keeps driving. Back-to-back accesses with no idle cycle between them show that the gathered word of one read is never mixed with the next read.

// File: rtl/ds_pkg.sv
package ds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2,
    ST_FIN    = 2'd3
  } ds_state_e;

  // True when beat 'beat' of a 'beats'-way split has to be issued.
  function automatic logic beat_wanted(input logic [3:0] be, input logic skip,
                                       input int beat, input int beats);
    int   per;
    logic hit;
    per = 4 / beats;
    hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if ((k / per) == beat && be[k]) hit = 1'b1;
    end
    return !skip || hit;
  endfunction

  // First wanted beat at index 'from' or above; -1 when none is left.
  function automatic int next_beat(input logic [3:0] be, input logic skip,
                                   input int from, input int beats);
    int found;
    found = -1;
    for (int b = 3; b >= 0; b--) begin
      if (b >= from && b < beats && beat_wanted(be, skip, b, beats)) found = b;
    end
    return found;
  endfunction

endpackage

// File: rtl/ds_beat_seq.sv
module ds_beat_seq
  import ds_pkg::*;
#(
  parameter int BEATS      = 2,
  parameter int BEAT_W     = 1,
  parameter int STROBE_CYC = 2,
  parameter int CNT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        be_in,
  input  logic              skip_in,
  output ds_state_e         state,
  output logic [BEAT_W-1:0] beat,
  output logic [3:0]        be_q,
  output logic              beat_done,
  output logic              xfer_done,
  output logic              skip_q
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  int               first_nb;
  int               gap_nb;

  always_comb begin
    first_nb  = next_beat(be_in, skip_in, 0, BEATS);
    gap_nb    = next_beat(be_q, skip_q, int'(beat) + 1, BEATS);
    beat_done = (state == ST_STROBE) && (cnt == LAST_CNT);
    xfer_done = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      beat   <= '0;
      cnt    <= '0;
      be_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            be_q   <= be_in;
            skip_q <= skip_in;
            cnt    <= '0;
            if (first_nb < 0) begin
              state <= ST_FIN;
            end else begin
              beat  <= BEAT_W'(first_nb);
              state <= ST_STROBE;
            end
          end
        end
        ST_STROBE: begin
          if (beat_done) state <= ST_GAP;
          else           cnt   <= cnt + 1'b1;
        end
        ST_GAP: begin
          cnt <= '0;
          if (gap_nb < 0) begin
            state <= ST_FIN;
          end else begin
            beat  <= BEAT_W'(gap_nb);
            state <= ST_STROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ds_slave_drive.sv
module ds_slave_drive
  import ds_pkg::*;
#(
  parameter int SDW     = 16,
  parameter int BEAT_W  = 1,
  parameter int MADDR_W = 8
) (
  input  ds_state_e             state,
  input  logic [BEAT_W-1:0]     beat,
  input  logic                  rd_q,
  input  logic [MADDR_W-1:0]    addr_q,
  input  logic [31:0]           wdata_q,
  input  logic [3:0]            be_q,
  output logic                  s_cs,
  output logic                  s_rd,
  output logic                  s_wr,
  output logic [MADDR_W+BEAT_W-1:0] s_addr,
  output logic [SDW/8-1:0]      s_be,
  output logic [SDW-1:0]        s_wdata
);

  localparam int BEB = SDW / 8;

  always_comb begin
    s_cs    = (state == ST_STROBE);
    s_rd    = s_cs && rd_q;
    s_wr    = s_cs && !rd_q;
    s_addr  = {addr_q, beat};
    s_be    = be_q[beat*BEB +: BEB];
    s_wdata = wdata_q[beat*SDW +: SDW];
  end

endmodule

// File: rtl/ds_read_gather.sv
module ds_read_gather #(
  parameter int SDW    = 16,
  parameter int BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [BEAT_W-1:0] beat,
  input  logic [SDW-1:0]    s_rdata,
  output logic [31:0]       word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (clear)   word <= '0;
    else if (capture) word[beat*SDW +: SDW] <= s_rdata;
  end

endmodule

// File: rtl/bus_downsizer.sv
module bus_downsizer
  import ds_pkg::*;
#(
  parameter int SLV_DW     = 16,  // 16 or 8
  parameter int MADDR_W    = 8,
  parameter int STROBE_CYC = 2,
  localparam int BEATS     = 32 / SLV_DW,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int SADDR_W   = MADDR_W + BEAT_W,
  localparam int SBE_W     = SLV_DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               skip_en,
  input  logic [MADDR_W-1:0] m_addr,
  input  logic               m_read,
  input  logic               m_write,
  input  logic [3:0]         m_be,
  input  logic [31:0]        m_wdata,
  output logic               m_waitreq,
  output logic [31:0]        m_rdata,
  output logic               m_rvalid,
  output logic               s_cs,
  output logic               s_rd,
  output logic               s_wr,
  output logic [SADDR_W-1:0] s_addr,
  output logic [SBE_W-1:0]   s_be,
  output logic [SLV_DW-1:0]  s_wdata,
  input  logic [SLV_DW-1:0]  s_rdata
);

  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  ds_state_e          state;
  logic [BEAT_W-1:0]  beat;
  logic [3:0]         be_q;
  logic               skip_q;
  logic               beat_done;   // last strobe cycle of a beat
  logic               xfer_done;   // completion cycle of the access
  logic               accept;      // request taken this edge
  logic               rd_q;
  logic [MADDR_W-1:0] addr_q;
  logic [31:0]        wdata_q;

  assign accept = (state == ST_IDLE) && (m_read || m_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      rd_q    <= m_read;
      addr_q  <= m_addr;
      wdata_q <= m_wdata;
    end
  end

  ds_beat_seq #(
    .BEATS(BEATS), .BEAT_W(BEAT_W), .STROBE_CYC(STROBE_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .be_in(m_be), .skip_in(skip_en),
    .state(state), .beat(beat), .be_q(be_q), .beat_done(beat_done),
    .xfer_done(xfer_done), .skip_q(skip_q)
  );

  ds_slave_drive #(
    .SDW(SLV_DW), .BEAT_W(BEAT_W), .MADDR_W(MADDR_W)
  ) u_drv (
    .state(state), .beat(beat), .rd_q(rd_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .be_q(be_q), .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr),
    .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata)
  );

  ds_read_gather #(
    .SDW(SLV_DW), .BEAT_W(BEAT_W)
  ) u_gather (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(beat_done && rd_q),
    .beat(beat), .s_rdata(s_rdata), .word(m_rdata)
  );

  assign m_waitreq = !xfer_done;
  assign m_rvalid  = xfer_done && rd_q;

endmodule

// File: rtl/ds_checker.sv
module ds_checker #(
  parameter int STROBE_CYC = 2,
  parameter int SADDR_W    = 9,
  parameter int SBE_W      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_cs,
  input logic               s_rd,
  input logic               s_wr,
  input logic [SADDR_W-1:0] s_addr,
  input logic [SBE_W-1:0]   s_be,
  input logic               m_rvalid,
  input logic               m_waitreq,
  input logic               skip_q,
  input logic               beat_done,
  input logic               xfer_done
);

  int run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (s_cs) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd || s_wr) |-> s_cs);                                    // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_rd && s_wr));                                            // R8
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_cs && $past(s_cs)) |-> (run_q == STROBE_CYC));           // R7
  AST_STROBE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |-> (run_q < STROBE_CYC));                              // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs && $past(s_cs)) |-> $stable(s_addr));                  // R7
  AST_BEAT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> s_cs);                                         // R7
  AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |=> !m_rvalid);                                     // R3
  AST_RVALID_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid |-> (!m_waitreq && xfer_done));                     // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !s_cs);                                        // R7
  AST_SKIP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && s_cs) |-> (s_be != '0));                          // R4

endmodule

bind bus_downsizer ds_checker #(
  .STROBE_CYC(STROBE_CYC), .SADDR_W(SADDR_W), .SBE_W(SBE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr),
  .s_addr(s_addr), .s_be(s_be), .m_rvalid(m_rvalid), .m_waitreq(m_waitreq),
  .skip_q(skip_q), .beat_done(beat_done), .xfer_done(xfer_done)
);

// File: tb/tb_bus_downsizer.sv
module tb_bus_downsizer;

  localparam int SDW  = 16;
  localparam int AW   = 8;
  localparam int SCYC = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            skip_en = 1'b0;
  logic [AW-1:0]   m_addr = '0;
  logic            m_read = 1'b0, m_write = 1'b0;
  logic [3:0]      m_be = '0;
  logic [31:0]     m_wdata = '0;
  logic            m_waitreq, m_rvalid;
  logic [31:0]     m_rdata;
  logic            s_cs, s_rd, s_wr;
  logic [AW:0]     s_addr;
  logic [1:0]      s_be;
  logic [SDW-1:0]  s_wdata, s_rdata;

  always #5 clk = ~clk;

  bus_downsizer #(.SLV_DW(SDW), .MADDR_W(AW), .STROBE_CYC(SCYC)) dut (
    .clk(clk), .rst_n(rst_n), .skip_en(skip_en), .m_addr(m_addr),
    .m_read(m_read), .m_write(m_write), .m_be(m_be), .m_wdata(m_wdata),
    .m_waitreq(m_waitreq), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
    .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr), .s_addr(s_addr), .s_be(s_be),
    .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // Slave model: 16 half-words, byte-writable, combinational read.
  logic [15:0] smem [16];
  assign s_rdata = smem[s_addr[3:0]];

  // Beat monitor: one log entry per rising chip-select.
  logic        prev_cs = 1'b0;
  int          nlog;
  logic [8:0]  lg_addr [8];
  logic [1:0]  lg_be   [8];
  logic [15:0] lg_wd   [8];
  logic        lg_rd   [8];
  logic        lg_wr   [8];
  int          cs_cyc;

  always @(posedge clk) begin
    if (s_cs) cs_cyc++;
    if (s_cs && !prev_cs && nlog < 8) begin
      lg_addr[nlog] = s_addr;
      lg_be[nlog]   = s_be;
      lg_wd[nlog]   = s_wdata;
      lg_rd[nlog]   = s_rd;
      lg_wr[nlog]   = s_wr;
      nlog++;
      if (s_wr) begin
        if (s_be[0]) smem[s_addr[3:0]][7:0]  = s_wdata[7:0];
        if (s_be[1]) smem[s_addr[3:0]][15:8] = s_wdata[15:8];
      end
    end
    prev_cs = s_cs;
  end

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // Run one access; returns word, valid flag and cycles to completion.
  task automatic xfer(input bit rd, input logic [AW-1:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input bit skip, input bit flip_skip,
                      output logic [31:0] rdat, output bit vld, output int cyc);
    @(negedge clk);
    nlog = 0; cs_cyc = 0;
    m_addr = a; m_be = be; m_wdata = wd; skip_en = skip;
    m_read = rd; m_write = !rd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (flip_skip && cyc == 1) skip_en = !skip;
    end while (m_waitreq && cyc < 100);
    rdat = m_rdata; vld = m_rvalid;
    m_read = 1'b0; m_write = 1'b0;
    @(negedge clk);
    chk(!m_rvalid, "R3 rvalid single cycle", m_rvalid, 0);
  endtask

  function automatic int exp_cyc(input int n);
    return 1 + n * (SCYC + 1);
  endfunction

  logic [31:0] rd_w, exp_w;
  bit          vld;
  int          cyc;
  logic [15:0] keep;

  task automatic t_reset();
    chk(!s_cs && !s_rd && !s_wr, "R1 slave strobes idle", {s_cs, s_rd, s_wr}, 0);
    chk(!m_rvalid, "R1 rvalid low", m_rvalid, 0);
    chk(m_waitreq, "R1 waitreq high", m_waitreq, 1);
  endtask

  task automatic t_full_read();
    xfer(1, 8'd3, 4'hF, 0, 1, 0, rd_w, vld, cyc);
    exp_w = {smem[7], smem[6]};
    chk(nlog == 2, "R2 two beats", nlog, 2);
    chk(lg_addr[0] == 9'd6 && lg_addr[1] == 9'd7, "R2 ascending addresses",
        {lg_addr[0], lg_addr[1]}, {9'd6, 9'd7});
    chk(lg_rd[0] && lg_rd[1] && !lg_wr[0], "R8 read strobes only", {lg_rd[0], lg_rd[1]}, 3);
    chk(rd_w == exp_w && vld, "R3 assembled word", rd_w, exp_w);
    chk(cyc == exp_cyc(2), "R9 latency two beats", cyc, exp_cyc(2));
    chk(cs_cyc == 2 * SCYC, "R7 strobe width", cs_cyc, 2 * SCYC);
  endtask

  task automatic t_skip_low();
    xfer(1, 8'd5, 4'b0011, 0, 1, 0, rd_w, vld, cyc);
    chk(nlog == 1 && lg_addr[0] == 9'd10, "R4 only low beat strobed", lg_addr[0], 10);
    chk(rd_w == {16'h0, smem[10]}, "R4 skipped lanes zero", rd_w, {16'h0, smem[10]});
    chk(cyc == exp_cyc(1), "R9 latency one beat", cyc, exp_cyc(1));
  endtask

  task automatic t_skip_high();
    xfer(1, 8'd5, 4'b0100, 0, 1, 0, rd_w, vld, cyc);
    chk(nlog == 1 && lg_addr[0] == 9'd11, "R4 only high beat strobed", lg_addr[0], 11);
    chk(lg_be[0] == 2'b01, "R2 byte-enable slice", lg_be[0], 1);
    chk(rd_w == {smem[11], 16'h0}, "R4 high lane placed", rd_w, {smem[11], 16'h0});
  endtask

  task automatic t_split_mode();
    xfer(1, 8'd2, 4'b0011, 0, 0, 0, rd_w, vld, cyc);
    chk(nlog == 2, "R5 both beats issued", nlog, 2);
    chk(lg_be[1] == 2'b00, "R5 empty beat still strobed", lg_be[1], 0);
    chk(rd_w == {smem[5], smem[4]}, "R5 full word", rd_w, {smem[5], smem[4]});
  endtask

  task automatic t_write_skip();
    keep = smem[8];
    xfer(0, 8'd4, 4'b1100, 32'hDEAD_BEEF, 1, 0, rd_w, vld, cyc);
    chk(nlog == 1 && lg_addr[0] == 9'd9, "R4 write one beat", lg_addr[0], 9);
    chk(lg_wd[0] == 16'hDEAD && lg_be[0] == 2'b11 && lg_wr[0] && !lg_rd[0],
        "R8 write slice", lg_wd[0], 16'hDEAD);
    chk(smem[8] == keep, "R8 untouched half", smem[8], keep);
    chk(!vld, "R3 no rvalid on write", vld, 0);
  endtask

  task automatic t_write_split();
    smem[12] = 16'hAAAA; smem[13] = 16'hBBBB;
    xfer(0, 8'd6, 4'b0110, 32'h1122_3344, 0, 0, rd_w, vld, cyc);
    chk(nlog == 2 && lg_be[0] == 2'b10 && lg_be[1] == 2'b01, "R8 per-beat enables",
        {lg_be[0], lg_be[1]}, 4'b1001);
    chk(smem[12] == 16'h33AA, "R8 byte merge low", smem[12], 16'h33AA);
    chk(smem[13] == 16'hBB22, "R8 byte merge high", smem[13], 16'hBB22);
  endtask

  task automatic t_empty();
    xfer(1, 8'd1, 4'b0000, 0, 1, 0, rd_w, vld, cyc);
    chk(nlog == 0, "R6 no slave transfer", nlog, 0);
    chk(cyc == 1, "R6 immediate completion", cyc, 1);
    chk(rd_w == 0 && vld, "R6 zero word", rd_w, 0);
    xfer(0, 8'd1, 4'b0000, 32'hFFFF_FFFF, 1, 0, rd_w, vld, cyc);
    chk(nlog == 0 && smem[2] != 16'hFFFF, "R6 empty write", nlog, 0);
  endtask

  task automatic t_mode_sample();
    xfer(1, 8'd7, 4'b0011, 0, 1, 1, rd_w, vld, cyc);
    chk(nlog == 1, "R10 mode latched at accept", nlog, 1);
    chk(rd_w == {16'h0, smem[14]}, "R10 word follows latched mode", rd_w, {16'h0, smem[14]});
    xfer(1, 8'd7, 4'b0011, 0, 0, 1, rd_w, vld, cyc);
    chk(nlog == 2, "R10 split mode latched", nlog, 2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) smem[i] = 16'(16'h1000 * (i % 15) + 16'h0101 * i + 16'h0042);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_read();
    t_skip_low();
    t_skip_high();
    t_split_mode();
    t_write_skip();
    t_write_split();
    t_empty();
    t_mode_sample();
    t_full_read();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule